// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address. It walks a four-level tree of translation tables held in memory. A translation request is accepted through a valid/ready handshake. The walk then begins at the table named by a root-base input and makes one memory read per level, in fixed order. Each read uses a nine-bit slice of the virtual address as the table index. The address of the next table is taken from the entry that was just read.

Each entry is 64 bits wide. Bit 0 is a present flag, and bits [51:12] hold a 4 KiB-aligned frame number. An entry with the present flag clear ends the walk at once with a fault. An entry found at the last level supplies the page frame, which is joined with the low twelve address bits. The walker handles one request at a time. Its memory read port may stall for any number of cycles, both on the request and on the response.

Top module: `ptwalk4`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_rd_valid` and `res_valid` are 0.
- R2: The first read of a walk goes to address {root_base[51:12], va[47:39], 3'b000}. The low 12 bits of `root_base` have no effect.
- R3: The next reads go, in this order, to {prev_entry[51:12], va[38:30], 3'b000}, then {prev_entry[51:12], va[29:21], 3'b000}, then {prev_entry[51:12], va[20:12], 3'b000}.
- R4: When all four entries have bit 0 set, the result carries `res_fault`=0 and `res_pa` = {last_entry[51:12], va[11:0]}.
- R5: An entry with bit 0 clear stops the walk. No further read is issued, and the result carries `res_fault`=1 and `res_pa`=0.
- R6: `req_ready` goes low in the cycle after a request is accepted. It stays low until the result has been taken with `res_ready`.
- R7: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the request stays asserted and `mem_rd_addr` does not change.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_pa` and `res_fault` do not change.
- R9: At most one read is outstanding at a time, and a walk issues at most four reads. The number of reads equals the level at which the walk ends.
- R10: Entry bits [63:52] and [11:1] have no effect on the table addresses or on the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_base | input | 52 | Base address of the top-level table; bits [11:0] ignored |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | The walker is idle and can accept a request |
| req_va | input | 48 | Virtual address to translate |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 52 | Byte address of the table entry being read |
| mem_rsp_valid | input | 1 | Read data is returned this cycle |
| mem_rsp_data | input | 64 | Table entry returned by memory |
| res_valid | output | 1 | A translation result is available |
| res_ready | input | 1 | The consumer takes the result |
| res_pa | output | 52 | Translated physical address; 0 on a fault |
| res_fault | output | 1 | The walk met a non-present entry |

## Verification
Several properties are checked on every cycle. These are the handshake holds on the memory port and on the result port, the busy window of `req_ready`, and the rule of a single outstanding read. The cap of four reads per walk, the address of the first read, and the rule that a non-present entry ends the walk with a zero address are checked the same way. Only the bench scenarios show the rest. These are the full address sequence across levels, the frame taken from the final entry, and faults at each of the four levels. The same scenarios cover that entry flag bits and the low root bits are ignored, and that the walk behaves the same under different memory stall lengths.

// File: rtl/ptwalk4_pkg.sv
package ptwalk4_pkg;
  localparam int VA_W      = 48;
  localparam int PA_W      = 52;
  localparam int ENT_W     = 64;
  localparam int LVLS      = 4;
  localparam int IDX_W     = 9;
  localparam int OFF_W     = 12;
  localparam int ENT_LG    = $clog2(ENT_W / 8);
  localparam int FRAME_W   = PA_W - OFF_W;
  localparam int LVL_W     = $clog2(LVLS);
  localparam int CNT_W     = $clog2(LVLS + 1);

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ISSUE = 2'd1,
    WK_WAIT  = 2'd2,
    WK_DONE  = 2'd3
  } walk_st_e;

  // frame number held in an entry
  function automatic logic [FRAME_W-1:0] frame_of(input logic [ENT_W-1:0] ent);
    return ent[PA_W-1:OFF_W];
  endfunction

  // present flag of an entry
  function automatic logic present_of(input logic [ENT_W-1:0] ent);
    return ent[0];
  endfunction

  // frame number of the top-level table
  function automatic logic [FRAME_W-1:0] root_frame(input logic [PA_W-1:0] root);
    return root[PA_W-1:OFF_W];
  endfunction

  // aligned table base plus index scaled by entry size
  function automatic logic [PA_W-1:0] entry_addr(input logic [FRAME_W-1:0] frame,
                                                 input logic [IDX_W-1:0]   idx);
    return {frame, idx, {ENT_LG{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] make_pa(input logic [FRAME_W-1:0] frame,
                                              input logic [OFF_W-1:0]   off);
    return {frame, off};
  endfunction
endpackage

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel
  import ptwalk4_pkg::*;
(
  input  logic [VA_W-1:0]    va,
  input  logic [LVL_W-1:0]   lvl,
  input  logic [FRAME_W-1:0] tbl_frame,
  output logic [PA_W-1:0]    ent_addr
);
  logic [IDX_W-1:0] slice [LVLS];

  // level 0 takes the highest slice, the last level the one just above the offset
  for (genvar g = 0; g < LVLS; g++) begin : g_slice
    assign slice[g] = va[OFF_W + IDX_W*(LVLS-1-g) +: IDX_W];
  end

  assign ent_addr = entry_addr(tbl_frame, slice[lvl]);
endmodule

// File: rtl/ptw_walk_ctl.sv
module ptw_walk_ctl
  import ptwalk4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             mem_rd_ready,
  input  logic             mem_rsp_valid,
  input  logic             ent_present,
  input  logic             res_ready,
  output logic             req_ready,
  output logic             mem_rd_valid,
  output logic             res_valid,
  output logic [LVL_W-1:0] lvl,
  output logic             walk_start,
  output logic             rd_fire,
  output logic             rd_done,
  output logic             step_next,
  output logic             step_last,
  output logic             step_fault,
  output logic             walk_end
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LVLS - 1);

  walk_st_e st_q, st_d;
  logic [LVL_W-1:0] lvl_q;
  logic at_last;

  assign req_ready    = (st_q == WK_IDLE);
  assign mem_rd_valid = (st_q == WK_ISSUE);
  assign res_valid    = (st_q == WK_DONE);
  assign lvl          = lvl_q;
  assign at_last      = (lvl_q == LAST_LVL);

  assign walk_start = req_valid && req_ready;
  assign rd_fire    = mem_rd_valid && mem_rd_ready;
  assign rd_done    = (st_q == WK_WAIT) && mem_rsp_valid;
  assign step_fault = rd_done && !ent_present;
  assign step_last  = rd_done && ent_present && at_last;
  assign step_next  = rd_done && ent_present && !at_last;
  assign walk_end   = res_valid && res_ready;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WK_IDLE:  if (walk_start) st_d = WK_ISSUE;
      WK_ISSUE: if (rd_fire)    st_d = WK_WAIT;
      WK_WAIT: begin
        if (step_next)                    st_d = WK_ISSUE;
        else if (step_last || step_fault) st_d = WK_DONE;
      end
      WK_DONE:  if (walk_end)   st_d = WK_IDLE;
      default:                  st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WK_IDLE;
      lvl_q <= '0;
    end else begin
      st_q <= st_d;
      if (walk_start)     lvl_q <= '0;
      else if (step_next) lvl_q <= lvl_q + LVL_W'(1);
    end
  end
endmodule

// File: rtl/ptw_result.sv
module ptw_result
  import ptwalk4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_ok,
  input  logic             cap_fault,
  input  logic [ENT_W-1:0] ent,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa,
  output logic             fault
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa    <= '0;
      fault <= 1'b0;
    end else if (cap_ok) begin
      pa    <= make_pa(frame_of(ent), off);
      fault <= 1'b0;
    end else if (cap_fault) begin
      pa    <= '0;
      fault <= 1'b1;
    end
  end
endmodule

// File: rtl/ptwalk4.sv
module ptwalk4
  import ptwalk4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [PA_W-1:0]   res_pa,
  output logic              res_fault
);
  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] tbl_q;
  logic [LVL_W-1:0]   lvl;
  logic walk_start, rd_fire, rd_done, step_next, step_last, step_fault, walk_end;
  logic ent_present;

  assign ent_present = present_of(mem_rsp_data);

  ptw_walk_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .ent_present  (ent_present),
    .res_ready    (res_ready),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .res_valid    (res_valid),
    .lvl          (lvl),
    .walk_start   (walk_start),
    .rd_fire      (rd_fire),
    .rd_done      (rd_done),
    .step_next    (step_next),
    .step_last    (step_last),
    .step_fault   (step_fault),
    .walk_end     (walk_end)
  );

  // captured address and current table frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q  <= '0;
      tbl_q <= '0;
    end else if (walk_start) begin
      va_q  <= req_va;
      tbl_q <= root_frame(root_base);
    end else if (step_next) begin
      tbl_q <= frame_of(mem_rsp_data);
    end
  end

  ptw_idx_sel u_idx (
    .va       (va_q),
    .lvl      (lvl),
    .tbl_frame(tbl_q),
    .ent_addr (mem_rd_addr)
  );

  ptw_result u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_ok   (step_last),
    .cap_fault(step_fault),
    .ent      (mem_rsp_data),
    .off      (va_q[OFF_W-1:0]),
    .pa       (res_pa),
    .fault    (res_fault)
  );
endmodule

// File: rtl/ptwalk4_chk.sv
module ptwalk4_chk
  import ptwalk4_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [PA_W-1:0]  root_base,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_va,
  input logic             mem_rd_valid,
  input logic             mem_rd_ready,
  input logic [PA_W-1:0]  mem_rd_addr,
  input logic [ENT_W-1:0] mem_rsp_data,
  input logic             res_valid,
  input logic             res_ready,
  input logic [PA_W-1:0]  res_pa,
  input logic             res_fault,
  input logic             walk_start,
  input logic             rd_fire,
  input logic             rd_done
);
  logic             pend_q;
  logic [CNT_W-1:0] nrd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      nrd_q  <= '0;
    end else begin
      if (rd_fire)      pend_q <= 1'b1;
      else if (rd_done) pend_q <= 1'b0;
      if (walk_start)   nrd_q <= '0;
      else if (rd_fire) nrd_q <= nrd_q + CNT_W'(1);
    end
  end

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R6
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);
  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pa) && $stable(res_fault));
  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_pa == '0);
  // R5
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && !present_of(mem_rsp_data) |=> !mem_rd_valid && res_valid && res_fault);
  // R9
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !mem_rd_valid);
  // R9
  max_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> nrd_q < CNT_W'(LVLS));
  // R2
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> mem_rd_valid &&
      mem_rd_addr == {$past(root_base[PA_W-1:OFF_W]),
                      $past(req_va[VA_W-1:VA_W-IDX_W]), {ENT_LG{1'b0}}});
endmodule

bind ptwalk4 ptwalk4_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .root_base   (root_base),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_va      (req_va),
  .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr (mem_rd_addr),
  .mem_rsp_data(mem_rsp_data),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_pa      (res_pa),
  .res_fault   (res_fault),
  .walk_start  (walk_start),
  .rd_fire     (rd_fire),
  .rd_done     (rd_done)
);

// File: tb/ptwalk4_test.sv
`timescale 1ns/1ps
module ptwalk4_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] root_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [51:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [51:0] res_pa;
  logic        res_fault;

  int n_chk = 0;
  int n_bad = 0;
  int lat = 0;
  int rd_count = 0;
  logic [51:0] addr_log [4];

  always #4 clk = ~clk;

  ptwalk4 uut (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa), .res_fault(res_fault)
  );

  typedef struct packed {
    logic [51:0] root;
    logic [47:0] va;
    logic [3:0]  stall;
    logic [51:0] pa;
    logic        flt;
    logic [2:0]  nrd;
  } vec_t;

  // R4 ok walks, R5 faults at each level, R2 root low bits, R10 flag bits
  localparam vec_t VECS [7] = '{
    '{52'h1000, 48'h0080_8060_4ABC, 4'd0, 52'hF_EDCB_A987_6ABC, 1'b0, 3'd4},
    '{52'h1000, 48'h0080_8060_5001, 4'd2, 52'h0,                1'b1, 3'd4},
    '{52'h1000, 48'h0000_0000_0FFF, 4'd1, 52'h0,                1'b1, 3'd1},
    '{52'h1000, 48'hFFFF_FFFF_FFFF, 4'd3, 52'h0_0123_4567_8FFF, 1'b0, 3'd4},
    '{52'h1000, 48'h0080_0000_0123, 4'd0, 52'h0,                1'b1, 3'd2},
    '{52'h1000, 48'h0080_8000_0000, 4'd5, 52'h0,                1'b1, 3'd3},
    '{52'h1FFF, 48'h0080_8060_4ABC, 4'd1, 52'hF_EDCB_A987_6ABC, 1'b0, 3'd4}
  };

  function automatic logic [63:0] mem_at(input logic [51:0] a);
    case (a)
      52'h1008: return 64'hFFF0_0000_0000_2F03;  // R10 flag bits set
      52'h2010: return 64'h0000_0000_0000_3001;
      52'h3018: return 64'hFFF0_0000_0000_4FFF;  // R10 flag bits set
      52'h4020: return 64'h000F_EDCB_A987_6001;
      52'h4028: return 64'h0000_0000_0009_9000;  // not present
      52'h1FF8: return 64'h0000_0000_0000_5001;
      52'h5FF8: return 64'h0000_0000_0000_6001;
      52'h6FF8: return 64'h0000_0000_0000_7001;
      52'h7FF8: return 64'h0000_0123_4567_8001;
      default:  return 64'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder with programmable stall on request and response
  initial begin
    mem_rd_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rst_n && mem_rd_valid) begin
        repeat (lat) @(negedge clk);
        mem_rd_ready = 1'b1;
        if (rd_count < 4) addr_log[rd_count] = mem_rd_addr;
        rd_count++;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem_at(addr_log[(rd_count > 4) ? 3 : rd_count-1]);
      end
    end
  end

  task automatic run_walk(input vec_t v);
    bit busy_ok = 1'b1;
    logic [51:0] pa0;
    logic f0;
    lat = int'(v.stall);
    rd_count = 0;
    @(negedge clk);
    root_base = v.root;
    req_va = v.va;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R6", "ready after accept", 64'(req_ready), 64'h0);
    while (!res_valid) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    chk(busy_ok, "R6", "ready low during walk", 64'(busy_ok), 64'h1);
    pa0 = res_pa;
    f0 = res_fault;
    repeat (2) @(negedge clk);
    chk(res_valid && res_pa == pa0 && res_fault == f0, "R8", "result held",
        64'(res_pa), 64'(pa0));
    res_ready = 1'b1;
    chk(res_pa == v.pa, v.flt ? "R5" : "R4", "physical address", 64'(res_pa), 64'(v.pa));
    chk(res_fault == v.flt, v.flt ? "R5" : "R4", "fault flag", 64'(res_fault), 64'(v.flt));
    chk(rd_count == int'(v.nrd), "R9", "read count", 64'(rd_count), 64'(v.nrd));
    chk(addr_log[0] == {v.root[51:12], v.va[47:39], 3'b000}, "R2", "first read address",
        64'(addr_log[0]), 64'({v.root[51:12], v.va[47:39], 3'b000}));
    @(negedge clk);
    res_ready = 1'b0;
    chk(req_ready == 1'b1 && res_valid == 1'b0, "R6", "idle after handoff",
        64'(req_ready), 64'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'h1);
    chk(mem_rd_valid == 1'b0, "R1", "mem_rd_valid in reset", 64'(mem_rd_valid), 64'h0);
    chk(res_valid == 1'b0, "R1", "res_valid in reset", 64'(res_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_rd_valid == 1'b0, "R1", "idle after reset",
        64'(req_ready), 64'h1);

    for (int i = 0; i < 7; i++) run_walk(VECS[i]);

    // R3 order of table addresses for a full walk, R10 flag bits ignored
    run_walk(VECS[0]);
    chk(addr_log[1] == 52'h2010, "R3", "second level address", 64'(addr_log[1]), 64'h2010);
    chk(addr_log[2] == 52'h3018, "R3", "third level address",  64'(addr_log[2]), 64'h3018);
    chk(addr_log[3] == 52'h4020, "R10", "last level address",  64'(addr_log[3]), 64'h4020);

    // R3 all-ones indices on a different chain
    run_walk(VECS[3]);
    chk(addr_log[1] == 52'h5FF8 && addr_log[2] == 52'h6FF8 && addr_log[3] == 52'h7FF8,
        "R3", "max index chain", 64'(addr_log[3]), 64'h7FF8);

    // R7 long request stall: result must still be right
    run_walk('{52'h1000, 48'h0080_8060_4ABC, 4'd9, 52'hF_EDCB_A987_6ABC, 1'b0, 3'd4});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule